// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several requesters perform atomic read-modify-write sequences on one shared word-addressed memory. Each requester has a valid/ready request port. It can issue a plain load, a plain store, a linked load, or a conditional store. The block answers one cycle later with read data and a success flag.

The block holds one reservation slot per requester. A slot is a small two-state machine with an address register:

- **States:**
  - `RSV_EMPTY`: no reservation is held.
  - `RSV_ARMED`: a reservation is held on the stored address.
- **Transitions:**
  - `link` (EMPTY→ARMED): the requester's own linked load is granted.
  - `relink` (ARMED→ARMED): another linked load by the same requester moves the reservation to a new address.
  - `consume` (ARMED→EMPTY): the requester's own conditional store is granted, whether or not it succeeds.
  - `snoop_kill` (ARMED→EMPTY): another requester writes the reserved address.

A conditional store commits only when its slot is armed on the same address. In every other case it fails. A failed conditional store leaves memory untouched and causes no write, so it kills no other requester's reservation. Software branches back and retries when the flag reads 0.

Only one operation reaches the single memory port per cycle. The port is given by fixed priority to the lowest-indexed requester that is asking. A typical lock loop runs as follows:
1. Linked load of the lock word.
2. Conditional store of a nonzero value.
3. Retry on failure.
4. A plain store of zero to release the lock.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every reservation is empty and no response is valid. A conditional store issued after reset therefore fails, even if that requester held a reservation before reset.
- R2: A linked load (op code 2) returns the addressed word on `rsp_rdata` with `rsp_ok`=1. It arms that requester's reservation on that address.
- R3: A conditional store (op code 3) whose reservation is armed on the same address, with no intervening write by another requester, writes its data and returns `rsp_ok`=1 and `rsp_rdata`=0.
- R4: A failed conditional store returns `rsp_ok`=0 and `rsp_rdata`=0, and the memory word is left unchanged.
- R5: A successful write by one requester empties every other requester's reservation on that address. This includes a plain store of zero used as an unlock.
- R6: A write to a different address leaves a reservation armed.
- R7: A conditional store consumes the issuing requester's own reservation. A second conditional store without a new linked load fails.
- R8: A conditional store with no armed reservation, or to an address other than the reserved one, fails.
- R9: At most one request is granted per cycle. `req_ready` goes only to the lowest-indexed requester with `req_valid` high.
- R10: A granted request gets its response on the next cycle, with `rsp_valid` one-hot on that requester. No response appears in a cycle after no grant.
- R11: A load (op code 0) returns the addressed word. A store (op code 1) writes `wdata`. Both return `rsp_ok`=1, and a store returns `rsp_rdata`=0.
- R12: When two requesters issue conditional stores to a shared reserved address in the same cycle, the one granted first commits. The other then fails and its data is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Request valid, one bit per requester |
| req_op | input | 2*NUM_REQ | Operation per requester: 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr | input | ADDR_W*NUM_REQ | Word address per requester |
| req_wdata | input | DATA_W*NUM_REQ | Write data per requester |
| req_ready | output | NUM_REQ | Grant, one-hot, lowest index wins |
| rsp_valid | output | NUM_REQ | Response valid, one-hot on the requester granted in the previous cycle |
| rsp_rdata | output | DATA_W | Read data for loads and linked loads, zero otherwise |
| rsp_ok | output | 1 | 1 for success, 0 for a failed conditional store |

## Verification
Two functions meet in one cycle when two requesters holding reservations on the same word both present conditional stores:
- the arbiter's grant decision;
- the reservation kill caused by the winner's write.

The bench provokes this by raising both requests on the same falling edge. It then judges three things:
- the one-hot `req_ready` before the edge;
- a success flag for the lower index, followed by a failure flag for the higher index one cycle later;
- a final load showing that only the winner's data reached memory.

A second coincidence is a plain unlock store landing while other slots are armed on that address. The bench judges it by the later failure of those slots' conditional stores.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } llsc_op_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_ARMED = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic found;

    always_comb begin
        gnt   = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                found  = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_link,
    input  logic              own_cond,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_fire,
    input  logic [IDX_W-1:0]  wr_owner,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              armed,
    output logic [ADDR_W-1:0] rsv_addr
);
    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              snoop_kill;

    assign snoop_kill = wr_fire && (wr_owner != IDX_W'(MY_ID)) && (wr_addr == addr_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (own_link) begin
                addr_q <= op_addr;
            end
        end
    end

    // transitions: link, relink, consume, snoop_kill
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (own_link) state_d = RSV_ARMED;
            end
            RSV_ARMED: begin
                if (own_link)        state_d = RSV_ARMED;
                else if (own_cond)   state_d = RSV_EMPTY;
                else if (snoop_kill) state_d = RSV_EMPTY;
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        armed    = (state_q == RSV_ARMED);
        rsv_addr = addr_q;
    end
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[addr];
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [2*NUM_REQ-1:0]      req_op,
    input  logic [ADDR_W*NUM_REQ-1:0] req_addr,
    input  logic [DATA_W*NUM_REQ-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        req_ready,
    output logic [NUM_REQ-1:0]        rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      rsp_ok
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [1:0]        op_a    [NUM_REQ];
    logic [ADDR_W-1:0] addr_a  [NUM_REQ];
    logic [DATA_W-1:0] wdata_a [NUM_REQ];
    logic [ADDR_W-1:0] rsv_addr_a [NUM_REQ];
    logic [NUM_REQ-1:0] rsv_armed;

    logic [NUM_REQ-1:0] gnt;
    logic               gnt_any;
    logic [IDX_W-1:0]   gnt_idx;

    llsc_op_e          sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              cond_pass;
    logic              mem_we;
    logic              mem_re;
    logic [DATA_W-1:0] mem_q;

    logic [NUM_REQ-1:0] rsp_valid_q;
    logic               rsp_ok_q;
    logic               rsp_rd_q;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_unpack
        assign op_a[g]    = req_op[2*g +: 2];
        assign addr_a[g]  = req_addr[ADDR_W*g +: ADDR_W];
        assign wdata_a[g] = req_wdata[DATA_W*g +: DATA_W];
    end

    llsc_prio_arb #(.N(NUM_REQ), .IDX_W(IDX_W)) u_arb (
        .req (req_valid),
        .gnt (gnt),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    assign req_ready = gnt;

    always_comb begin
        sel_op    = llsc_op_e'(op_a[gnt_idx]);
        sel_addr  = addr_a[gnt_idx];
        sel_wdata = wdata_a[gnt_idx];
        cond_pass = rsv_armed[gnt_idx] && (rsv_addr_a[gnt_idx] == sel_addr);
        mem_we    = gnt_any && ((sel_op == OP_STORE) || ((sel_op == OP_COND) && cond_pass));
        mem_re    = gnt_any && ((sel_op == OP_LOAD) || (sel_op == OP_LINK));
    end

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
        llsc_rsv_slot #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MY_ID(g)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .own_link (gnt[g] && (sel_op == OP_LINK)),
            .own_cond (gnt[g] && (sel_op == OP_COND)),
            .op_addr  (sel_addr),
            .wr_fire  (mem_we),
            .wr_owner (gnt_idx),
            .wr_addr  (sel_addr),
            .armed    (rsv_armed[g]),
            .rsv_addr (rsv_addr_a[g])
        );
    end

    llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (mem_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= '0;
            rsp_ok_q    <= 1'b0;
            rsp_rd_q    <= 1'b0;
        end else begin
            rsp_valid_q <= gnt;
            rsp_ok_q    <= gnt_any && ((sel_op != OP_COND) || cond_pass);
            rsp_rd_q    <= mem_re;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_ok    = rsp_ok_q;
    assign rsp_rdata = rsp_rd_q ? mem_q : '0;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int NUM_REQ = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_REQ-1:0]   req_valid,
    input logic [2*NUM_REQ-1:0] req_op,
    input logic [NUM_REQ-1:0]   req_ready,
    input logic [NUM_REQ-1:0]   rsp_valid,
    input logic                 rsp_ok,
    input logic                 mem_we,
    input logic [NUM_REQ-1:0]   rsv_armed
);
    logic gnt_is_cond;

    always_comb begin
        gnt_is_cond = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_ready[i] && (req_op[2*i +: 2] == 2'd3)) gnt_is_cond = 1'b1;
        end
    end

    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (rsv_armed == '0) && (rsp_valid == '0));

    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_ready[0]);

    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> (rsp_valid == $past(req_ready)));

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> (rsp_valid == '0));

    a_r3_write_flags_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_is_cond && mem_we) |=> rsp_ok);

    a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_is_cond && !mem_we) |=> !rsp_ok);

    a_r8_commit_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_is_cond && mem_we) |-> ((rsv_armed & req_ready) != '0));
endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .mem_we    (mem_we),
    .rsv_armed (rsv_armed)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;
    localparam int NR = 4;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NV = 19;

    // entry: id[46:45] op[44:43] addr[42:37] wdata[36:21] ok[20] rdata[19:4] tag[3:0]
    localparam logic [46:0] VEC [NV] = '{
        {2'd0, 2'd1, 6'd5, 16'h1111, 1'b1, 16'h0000, 4'd11},
        {2'd1, 2'd2, 6'd5, 16'h0000, 1'b1, 16'h1111, 4'd2},
        {2'd1, 2'd3, 6'd5, 16'h2222, 1'b1, 16'h0000, 4'd3},
        {2'd0, 2'd0, 6'd5, 16'h0000, 1'b1, 16'h2222, 4'd11},
        {2'd1, 2'd3, 6'd5, 16'h3333, 1'b0, 16'h0000, 4'd7},
        {2'd0, 2'd0, 6'd5, 16'h0000, 1'b1, 16'h2222, 4'd4},
        {2'd2, 2'd2, 6'd5, 16'h0000, 1'b1, 16'h2222, 4'd2},
        {2'd3, 2'd2, 6'd5, 16'h0000, 1'b1, 16'h2222, 4'd2},
        {2'd3, 2'd1, 6'd5, 16'h0000, 1'b1, 16'h0000, 4'd5},
        {2'd2, 2'd3, 6'd5, 16'h4444, 1'b0, 16'h0000, 4'd5},
        {2'd2, 2'd0, 6'd5, 16'h0000, 1'b1, 16'h0000, 4'd4},
        {2'd0, 2'd1, 6'd7, 16'h0abc, 1'b1, 16'h0000, 4'd11},
        {2'd1, 2'd2, 6'd7, 16'h0000, 1'b1, 16'h0abc, 4'd2},
        {2'd1, 2'd3, 6'd5, 16'h5555, 1'b0, 16'h0000, 4'd8},
        {2'd1, 2'd2, 6'd7, 16'h0000, 1'b1, 16'h0abc, 4'd2},
        {2'd0, 2'd1, 6'd8, 16'h0bbb, 1'b1, 16'h0000, 4'd6},
        {2'd1, 2'd3, 6'd7, 16'h7777, 1'b1, 16'h0000, 4'd6},
        {2'd0, 2'd0, 6'd7, 16'h0000, 1'b1, 16'h7777, 4'd3},
        {2'd3, 2'd0, 6'd5, 16'h0000, 1'b1, 16'h0000, 4'd8}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NR-1:0]    req_valid = '0;
    logic [2*NR-1:0]  req_op = '0;
    logic [AW*NR-1:0] req_addr = '0;
    logic [DW*NR-1:0] req_wdata = '0;
    logic [NR-1:0]    req_ready;
    logic [NR-1:0]    rsp_valid;
    logic [DW-1:0]    rsp_rdata;
    logic             rsp_ok;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    llsc_monitor #(.NUM_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_ok    (rsp_ok)
    );

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        req_valid[id]         = 1'b1;
        req_op[2*id +: 2]     = op;
        req_addr[AW*id +: AW] = a;
        req_wdata[DW*id +: DW] = wd;
    endtask

    // one op: drive on a falling edge, granted on the next rising edge,
    // response registered there and sampled on the following falling edge
    task automatic run_op(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd);
        @(negedge clk);
        put(id, op, a, wd);
        @(posedge clk);
        @(negedge clk);
        req_valid[id] = 1'b0;
    endtask

    function automatic logic [31:0] pack_rsp(input logic [NR-1:0] v, input logic ok,
                                             input logic [DW-1:0] d);
        return {8'h0, 4'(v), 3'b0, ok, d};
    endfunction

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {28'h0, rsp_valid}, 32'h0);
        check("R1", {28'h0, req_ready}, 32'h0);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [46:0] v;
            v = VEC[k];
            run_op(int'(v[46:45]), v[44:43], v[42:37], v[36:21]);
            check(tag_name(v[3:0]), pack_rsp(rsp_valid, rsp_ok, rsp_rdata),
                  pack_rsp(NR'(1) << v[46:45], v[20], v[19:4]));
        end

        // R10: idle cycle gives no response
        @(negedge clk);
        check("R10", {28'h0, rsp_valid}, 32'h0);

        // R1: requester 3 still holds a5; reset must drop it
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_op(3, 2'd3, 6'd5, 16'h9999);
        check("R1", pack_rsp(rsp_valid, rsp_ok, rsp_rdata), pack_rsp(4'b1000, 1'b0, 16'h0));
        run_op(0, 2'd0, 6'd5, 16'h0);
        check("R1", pack_rsp(rsp_valid, rsp_ok, rsp_rdata), pack_rsp(4'b0001, 1'b1, 16'h0));

        // R12: same-cycle conditional stores from two armed requesters
        run_op(0, 2'd1, 6'd9, 16'h0010);
        run_op(1, 2'd2, 6'd9, 16'h0);
        check("R2", pack_rsp(rsp_valid, rsp_ok, rsp_rdata), pack_rsp(4'b0010, 1'b1, 16'h0010));
        run_op(2, 2'd2, 6'd9, 16'h0);
        @(negedge clk);
        put(1, 2'd3, 6'd9, 16'h00a1);
        put(2, 2'd3, 6'd9, 16'h00a2);
        #1;
        check("R9", {28'h0, req_ready}, 32'h2);
        @(posedge clk);
        @(negedge clk);
        check("R10", pack_rsp(rsp_valid, rsp_ok, rsp_rdata), pack_rsp(4'b0010, 1'b1, 16'h0));
        req_valid[1] = 1'b0;
        #1;
        check("R9", {28'h0, req_ready}, 32'h4);
        @(posedge clk);
        @(negedge clk);
        check("R12", pack_rsp(rsp_valid, rsp_ok, rsp_rdata), pack_rsp(4'b0100, 1'b0, 16'h0));
        req_valid[2] = 1'b0;
        run_op(3, 2'd0, 6'd9, 16'h0);
        check("R12", pack_rsp(rsp_valid, rsp_ok, rsp_rdata), pack_rsp(4'b1000, 1'b1, 16'h00a1));

        summary();
        $finish;
    end
endmodule